// File: doc/BRIEF.md
# Hashed Page Table Walker

This block locates the translation entry for one 32-bit effective address in a hashed page table held in memory. The caller supplies the 24-bit virtual segment identifier taken from the selected segment register, the effective address, the table's base address and its hash mask, and pulses `start`. The walker derives a group offset from a hash of the segment identifier and the page index. It then reads the eight entries of that group over a simple memory port, for each entry the first word before the second. If no entry in the group matches, it probes a second group derived from the complemented hash.

A completed search is signalled by a one-cycle `search_done` pulse with either `found` or `miss`. On a hit, the entry's offset inside the table and both of its words are presented. Permission decoding is done outside the block. The caller returns its verdict on the `grant_valid`/`grant_ok` pair. On a granted access the walker sets the entry's referenced bit and, for a store, its changed bit, using single-byte writes. For a granted non-store access to an entry whose changed bit is clear, it raises `withhold_wr` so that write permission is not cached. The end of every walk is marked by `done`.

Top module: `hptw_walker`

## Requirements
- R1: After reset, `busy`, `done`, `search_done`, `found`, `miss`, `withhold_wr`, `mem_rd_req` and `mem_wr_req` are all low.
- R2: The page index is ea[27:12] and the hash is vsid XOR the zero-extended page index. The primary group offset is (hash << 6) AND `htab_mask`, and the first read goes to `htab_base` plus that offset.
- R3: Entries are 8 bytes, with eight to a group. They are visited in ascending offset order. For each entry, word 0 (byte offset 0) is read before word 1 (byte offset 4), and each word is one read.
- R4: An entry matches only if word0 bit 31 (valid) is set, word0 bit 6 (secondary flag) equals the current probe's flag, word0[30:7] equals vsid, and word0[5:0] equals ea[27:22].
- R5: When the eight primary entries all fail, eight entries are read from the group at offset (~hash << 6) AND `htab_mask`, computed in 32 bits. A match there requires the secondary flag to be set.
- R6: On the first match, `found` rises with `search_done`. `pte_off` then equals the group offset plus 8 times the entry index, and `pte_w0`/`pte_w1` hold the entry's words. No further entries are read.
- R7: When all sixteen entries fail, `miss` rises with `search_done` after exactly 32 reads, and `done` follows with no writes.
- R8: A `start` pulse while `busy` is high is ignored, and the running walk completes with the values latched at its own start.
- R9: After a hit and a granted access with word1 bit 8 (referenced) clear, one byte write goes to entry offset 6. Its data is word1[15:8] OR 0x01.
- R10: After a granted store with word1 bit 7 (changed) clear, one byte write goes to entry offset 7. Its data is word1[7:0] OR 0x80. This write comes after the referenced-bit write when both are needed.
- R11: After a granted non-store access with word1 bit 7 clear, no changed-bit write occurs and `withhold_wr` is high at `done`.
- R12: A denied access (`grant_ok` low) ends the walk with no writes and `withhold_wr` low.
- R13: A memory request holds its address until `mem_ack`, and a read and a write are never requested together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| vsid | input | 24 | Virtual segment identifier |
| ea | input | 32 | Effective address |
| htab_base | input | 32 | Byte address of the table |
| htab_mask | input | 32 | Mask applied to group offsets |
| is_store | input | 1 | The access being translated is a store |
| grant_valid | input | 1 | Permission verdict present |
| grant_ok | input | 1 | Verdict: access allowed |
| busy | output | 1 | Walk in progress |
| search_done | output | 1 | One-cycle pulse: search resolved |
| found | output | 1 | Matching entry located |
| miss | output | 1 | Both groups exhausted |
| pte_off | output | 32 | Entry offset within the table |
| pte_w0 | output | 32 | Entry word 0 |
| pte_w1 | output | 32 | Entry word 1 |
| withhold_wr | output | 1 | Write permission must not be cached |
| done | output | 1 | One-cycle pulse: walk finished |
| mem_rd_req | output | 1 | Word read request |
| mem_wr_req | output | 1 | Byte write request |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Byte write data |
| mem_ack | input | 1 | Request accepted, read data valid |
| mem_rdata | input | 32 | Read word |

## Verification
A corrupted index or probe flag appears on the memory port at the very next request, as an address out of ascending order or in the wrong group. The bench checks this against its log of read addresses. A wrong match decision appears within one cycle of the deciding read, as a premature `found`, a read count other than the expected one, or a `miss` where an entry exists. Faults in the referenced/changed update appear as a wrong byte address or data, as an extra or missing write before `done`, or as a wrong `withhold_wr` level. Each of these is observed within a few cycles of the grant.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

   // Entry word layout (positions the walker decodes or writes back)
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned VALID_BIT = 31;
   localparam int unsigned SEC_BIT   = 6;
   localparam int unsigned TAG_LSB   = 7;
   localparam int unsigned REF_BIT   = 8;
   localparam int unsigned CHG_BIT   = 7;

   // Byte offsets within an entry
   localparam int unsigned W0_BYTE   = 0;
   localparam int unsigned W1_BYTE   = 4;
   localparam int unsigned REF_BYTE  = 6;
   localparam int unsigned CHG_BYTE  = 7;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_RD0   = 3'd1,
      S_RD1   = 3'd2,
      S_EVAL  = 3'd3,
      S_GRANT = 3'd4,
      S_WR_R  = 3'd5,
      S_WR_C  = 3'd6,
      S_DONE  = 3'd7
   } hptw_state_e;

endpackage

// File: rtl/hptw_hash.sv
module hptw_hash #(
   parameter int unsigned VSID_W      = 24,
   parameter int unsigned PIDX_W      = 16,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned GROUP_SHIFT = 6,
   parameter int unsigned API_BITS    = 6
) (
   input  logic [VSID_W-1:0]   vsid,
   input  logic [PIDX_W-1:0]   pidx,
   input  logic [ADDR_W-1:0]   mask,
   input  logic                second,
   output logic [ADDR_W-1:0]   grp_off,
   output logic [API_BITS-1:0] api
);

   logic [VSID_W-1:0] hash;
   logic [ADDR_W-1:0] hash_w;
   logic [ADDR_W-1:0] hash_sel;

   generate
      if (VSID_W > PIDX_W) begin : g_pad_pidx
         assign hash = vsid ^ {{(VSID_W-PIDX_W){1'b0}}, pidx};
      end else if (VSID_W == PIDX_W) begin : g_same_pidx
         assign hash = vsid ^ pidx;
      end else begin : g_bad_pidx
         $error("hptw_hash: page index wider than segment id");
      end

      if (ADDR_W > VSID_W) begin : g_pad_hash
         assign hash_w = {{(ADDR_W-VSID_W){1'b0}}, hash};
      end else if (ADDR_W == VSID_W) begin : g_same_hash
         assign hash_w = hash;
      end else begin : g_bad_hash
         $error("hptw_hash: address narrower than hash");
      end

      if (API_BITS > PIDX_W) begin : g_bad_api
         $error("hptw_hash: api field wider than page index");
      end
   endgenerate

   // Secondary probe uses the full-width complement of the hash
   assign hash_sel = second ? ~hash_w : hash_w;
   assign grp_off  = (hash_sel << GROUP_SHIFT) & mask;
   assign api      = pidx[PIDX_W-1 -: API_BITS];

endmodule

// File: rtl/hptw_match.sv
module hptw_match
   import hptw_pkg::*;
#(
   parameter int unsigned VSID_W   = 24,
   parameter int unsigned API_BITS = 6
) (
   input  logic [WORD_W-1:0]   w0,
   input  logic [VSID_W-1:0]   vsid,
   input  logic [API_BITS-1:0] api,
   input  logic                second,
   output logic                hit
);

   generate
      if (TAG_LSB + VSID_W != VALID_BIT) begin : g_bad_tag
         $error("hptw_match: segment id does not fill the tag field");
      end
      if (API_BITS != SEC_BIT) begin : g_bad_api
         $error("hptw_match: api field must sit just below the secondary flag");
      end
   endgenerate

   logic valid_ok;
   logic sec_ok;
   logic tag_ok;
   logic api_ok;

   assign valid_ok = w0[VALID_BIT];
   assign sec_ok   = (w0[SEC_BIT] == second);
   assign tag_ok   = (w0[TAG_LSB +: VSID_W] == vsid);
   assign api_ok   = (w0[API_BITS-1:0] == api);
   assign hit      = valid_ok & sec_ok & tag_ok & api_ok;

endmodule

// File: rtl/hptw_addr.sv
module hptw_addr #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned IDX_W       = 3,
   parameter int unsigned ENTRY_SHIFT = 3
) (
   input  logic [ADDR_W-1:0]      base,
   input  logic [ADDR_W-1:0]      grp_off,
   input  logic [IDX_W-1:0]       idx,
   input  logic [ENTRY_SHIFT-1:0] bsel,
   output logic [ADDR_W-1:0]      entry_off,
   output logic [ADDR_W-1:0]      addr
);

   generate
      if (ADDR_W <= IDX_W + ENTRY_SHIFT) begin : g_bad_width
         $error("hptw_addr: address too narrow for a group");
      end
   endgenerate

   logic [ADDR_W-1:0] idx_w;
   logic [ADDR_W-1:0] bsel_w;

   assign idx_w     = {{(ADDR_W-IDX_W){1'b0}}, idx};
   assign bsel_w    = {{(ADDR_W-ENTRY_SHIFT){1'b0}}, bsel};
   assign entry_off = grp_off + (idx_w << ENTRY_SHIFT);
   assign addr      = base + entry_off + bsel_w;

endmodule

// File: rtl/hptw_walker.sv
module hptw_walker
   import hptw_pkg::*;
#(
   parameter int unsigned VSID_W      = 24,
   parameter int unsigned EA_W        = 32,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PAGE_BITS   = 12,
   parameter int unsigned SEG_BITS    = 28,
   parameter int unsigned ENTRIES     = 8,
   parameter int unsigned ENTRY_BYTES = 8,
   parameter int unsigned API_BITS    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VSID_W-1:0] vsid,
   input  logic [EA_W-1:0]   ea,
   input  logic [ADDR_W-1:0] htab_base,
   input  logic [ADDR_W-1:0] htab_mask,
   input  logic              is_store,
   input  logic              grant_valid,
   input  logic              grant_ok,
   output logic              busy,
   output logic              search_done,
   output logic              found,
   output logic              miss,
   output logic [ADDR_W-1:0] pte_off,
   output logic [WORD_W-1:0] pte_w0,
   output logic [WORD_W-1:0] pte_w1,
   output logic              withhold_wr,
   output logic              done,
   output logic              mem_rd_req,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata
);

   localparam int unsigned IDX_W       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam int unsigned ENTRY_SHIFT = $clog2(ENTRY_BYTES);
   localparam int unsigned GROUP_SHIFT = ENTRY_SHIFT + IDX_W;
   localparam int unsigned PIDX_W      = SEG_BITS - PAGE_BITS;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   generate
      if ((1 << IDX_W) != ENTRIES) begin : g_bad_entries
         $error("hptw_walker: entries per group must be a power of two");
      end
      if (ENTRY_BYTES != 8) begin : g_bad_entry_bytes
         $error("hptw_walker: entry must be two 32-bit words");
      end
      if (EA_W <= SEG_BITS || SEG_BITS <= PAGE_BITS) begin : g_bad_seg
         $error("hptw_walker: segment and page widths inconsistent");
      end
   endgenerate

   hptw_state_e          state_q;
   logic [VSID_W-1:0]    vsid_q;
   logic [PIDX_W-1:0]    pidx_q;
   logic [ADDR_W-1:0]    base_q;
   logic [ADDR_W-1:0]    mask_q;
   logic                 store_q;
   logic                 sec_q;
   logic [IDX_W-1:0]     idx_q;
   logic [WORD_W-1:0]    w0_q;
   logic [WORD_W-1:0]    w1_q;
   logic [ADDR_W-1:0]    off_q;
   logic                 found_q;
   logic                 miss_q;
   logic                 sdone_q;
   logic                 withhold_q;

   logic [ADDR_W-1:0]    grp_off;
   logic [API_BITS-1:0]  api;
   logic                 hit;
   logic [ADDR_W-1:0]    entry_off;
   logic [ENTRY_SHIFT-1:0] bsel;
   logic                 unused_ea;

   assign unused_ea = ^{ea[EA_W-1:SEG_BITS], ea[PAGE_BITS-1:0]};

   hptw_hash #(
      .VSID_W      (VSID_W),
      .PIDX_W      (PIDX_W),
      .ADDR_W      (ADDR_W),
      .GROUP_SHIFT (GROUP_SHIFT),
      .API_BITS    (API_BITS)
   ) u_hash (
      .vsid    (vsid_q),
      .pidx    (pidx_q),
      .mask    (mask_q),
      .second  (sec_q),
      .grp_off (grp_off),
      .api     (api)
   );

   hptw_match #(
      .VSID_W   (VSID_W),
      .API_BITS (API_BITS)
   ) u_match (
      .w0     (w0_q),
      .vsid   (vsid_q),
      .api    (api),
      .second (sec_q),
      .hit    (hit)
   );

   always_comb begin
      unique case (state_q)
         S_RD1:   bsel = ENTRY_SHIFT'(W1_BYTE);
         S_WR_R:  bsel = ENTRY_SHIFT'(REF_BYTE);
         S_WR_C:  bsel = ENTRY_SHIFT'(CHG_BYTE);
         default: bsel = ENTRY_SHIFT'(W0_BYTE);
      endcase
   end

   hptw_addr #(
      .ADDR_W      (ADDR_W),
      .IDX_W       (IDX_W),
      .ENTRY_SHIFT (ENTRY_SHIFT)
   ) u_addr (
      .base      (base_q),
      .grp_off   (grp_off),
      .idx       (idx_q),
      .bsel      (bsel),
      .entry_off (entry_off),
      .addr      (mem_addr)
   );

   // Decide what follows once the referenced bit is known to be set
   function automatic hptw_state_e after_ref(input logic chg, input logic st);
      if (chg) begin
         return S_DONE;
      end else if (st) begin
         return S_WR_C;
      end else begin
         return S_DONE;
      end
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         vsid_q     <= '0;
         pidx_q     <= '0;
         base_q     <= '0;
         mask_q     <= '0;
         store_q    <= 1'b0;
         sec_q      <= 1'b0;
         idx_q      <= '0;
         w0_q       <= '0;
         w1_q       <= '0;
         off_q      <= '0;
         found_q    <= 1'b0;
         miss_q     <= 1'b0;
         sdone_q    <= 1'b0;
         withhold_q <= 1'b0;
      end else begin
         sdone_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (start) begin
                  vsid_q     <= vsid;
                  pidx_q     <= ea[SEG_BITS-1:PAGE_BITS];
                  base_q     <= htab_base;
                  mask_q     <= htab_mask;
                  store_q    <= is_store;
                  sec_q      <= 1'b0;
                  idx_q      <= '0;
                  found_q    <= 1'b0;
                  miss_q     <= 1'b0;
                  withhold_q <= 1'b0;
                  state_q    <= S_RD0;
               end
            end
            S_RD0: begin
               if (mem_ack) begin
                  w0_q    <= mem_rdata;
                  state_q <= S_RD1;
               end
            end
            S_RD1: begin
               if (mem_ack) begin
                  w1_q    <= mem_rdata;
                  state_q <= S_EVAL;
               end
            end
            S_EVAL: begin
               if (hit) begin
                  found_q <= 1'b1;
                  sdone_q <= 1'b1;
                  off_q   <= entry_off;
                  state_q <= S_GRANT;
               end else if (idx_q == LAST_IDX) begin
                  if (!sec_q) begin
                     sec_q   <= 1'b1;
                     idx_q   <= '0;
                     state_q <= S_RD0;
                  end else begin
                     miss_q  <= 1'b1;
                     sdone_q <= 1'b1;
                     state_q <= S_DONE;
                  end
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= S_RD0;
               end
            end
            S_GRANT: begin
               if (grant_valid) begin
                  if (!grant_ok) begin
                     state_q <= S_DONE;
                  end else if (!w1_q[REF_BIT]) begin
                     state_q <= S_WR_R;
                  end else begin
                     state_q <= after_ref(w1_q[CHG_BIT], store_q);
                     if (!w1_q[CHG_BIT] && !store_q) begin
                        withhold_q <= 1'b1;
                     end
                  end
               end
            end
            S_WR_R: begin
               if (mem_ack) begin
                  state_q <= after_ref(w1_q[CHG_BIT], store_q);
                  if (!w1_q[CHG_BIT] && !store_q) begin
                     withhold_q <= 1'b1;
                  end
               end
            end
            S_WR_C: begin
               if (mem_ack) begin
                  state_q <= S_DONE;
               end
            end
            S_DONE: begin
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != S_IDLE);
   assign done        = (state_q == S_DONE);
   assign search_done = sdone_q;
   assign found       = found_q;
   assign miss        = miss_q;
   assign pte_off     = off_q;
   assign pte_w0      = w0_q;
   assign pte_w1      = w1_q;
   assign withhold_wr = withhold_q;
   assign mem_rd_req  = (state_q == S_RD0) || (state_q == S_RD1);
   assign mem_wr_req  = (state_q == S_WR_R) || (state_q == S_WR_C);
   assign mem_wdata   = (state_q == S_WR_C) ? (w1_q[7:0] | 8'h80)
                                            : (w1_q[15:8] | 8'h01);

endmodule

// File: rtl/hptw_walker_checker.sv
module hptw_walker_checker
   import hptw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              search_done,
   input logic              found,
   input logic              miss,
   input logic              mem_rd_req,
   input logic              mem_wr_req,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_wdata,
   input logic [WORD_W-1:0] pte_w0,
   input hptw_state_e       state_q,
   input logic              store_q
);

   assert_rd_wr_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req));

   assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_ack) |=> (mem_rd_req && $stable(mem_addr)));

   assert_wr_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !mem_ack) |=> (mem_wr_req && $stable(mem_addr) && $stable(mem_wdata)));

   assert_hit_not_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(found && miss));

   assert_found_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> pte_w0[VALID_BIT]);

   assert_sdone_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
      search_done |-> (found || miss));

   assert_ref_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WR_R) |-> (mem_wr_req && mem_wdata[0]));

   assert_chg_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WR_C) |-> (store_q && mem_wdata[7]));

   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

endmodule

bind hptw_walker hptw_walker_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .done        (done),
   .search_done (search_done),
   .found       (found),
   .miss        (miss),
   .mem_rd_req  (mem_rd_req),
   .mem_wr_req  (mem_wr_req),
   .mem_ack     (mem_ack),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .pte_w0      (pte_w0),
   .state_q     (state_q),
   .store_q     (store_q)
);

// File: tb/hptw_walker_bench.sv
module hptw_walker_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;
   localparam logic [31:0] BASE = 32'h0000_2000;
   localparam logic [31:0] MASK = 32'h0000_1FC0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] vsid = '0;
   logic [31:0] ea = '0;
   logic [31:0] htab_base = BASE;
   logic [31:0] htab_mask = MASK;
   logic        is_store = 1'b0;
   logic        grant_valid = 1'b0;
   logic        grant_ok = 1'b0;
   logic        busy, search_done, found, miss, withhold_wr, done;
   logic [31:0] pte_off, pte_w0, pte_w1;
   logic        mem_rd_req, mem_wr_req;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_ack;
   logic [31:0] mem_rdata;

   // memory model and logs
   logic [31:0] mem [0:4095];
   logic [31:0] rd_log [0:63];
   logic [31:0] wr_addr_log [0:3];
   logic [7:0]  wr_data_log [0:3];
   int          rd_cnt;
   int          wr_cnt;
   logic        clr_mem = 1'b0;
   logic        clr_log = 1'b0;
   logic        ld_en = 1'b0;
   logic [31:0] ld_addr = '0;
   logic [31:0] ld_val = '0;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hptw_walker u_hptw_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .vsid(vsid), .ea(ea),
      .htab_base(htab_base), .htab_mask(htab_mask), .is_store(is_store),
      .grant_valid(grant_valid), .grant_ok(grant_ok), .busy(busy),
      .search_done(search_done), .found(found), .miss(miss),
      .pte_off(pte_off), .pte_w0(pte_w0), .pte_w1(pte_w1),
      .withhold_wr(withhold_wr), .done(done), .mem_rd_req(mem_rd_req),
      .mem_wr_req(mem_wr_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (clr_mem) begin
         for (int i = 0; i < 4096; i++) mem[i] <= '0;
      end
      if (clr_log) begin
         rd_cnt <= 0;
         wr_cnt <= 0;
      end
      if (ld_en) mem[ld_addr[13:2]] <= ld_val;
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else if ((mem_rd_req || mem_wr_req) && !mem_ack) begin
         mem_ack   <= 1'b1;
         mem_rdata <= mem[mem_addr[13:2]];
         if (mem_rd_req) begin
            rd_log[rd_cnt[5:0]] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
         end else begin
            mem[mem_addr[13:2]][31 - 8*mem_addr[1:0] -: 8] <= mem_wdata;
            wr_addr_log[wr_cnt[1:0]] <= mem_addr;
            wr_data_log[wr_cnt[1:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(negedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] grp(input logic [23:0] v, input logic [31:0] e, input logic sec);
      logic [31:0] h;
      h = {8'h00, v ^ {8'h00, e[27:12]}};
      if (sec) h = ~h;
      return (h << 6) & MASK;
   endfunction

   function automatic logic [31:0] mkw0(input logic valid, input logic [23:0] v,
                                        input logic sec, input logic [31:0] e);
      return {valid, v, sec, e[27:22]};
   endfunction

   task automatic clear_env;
      @(negedge clk);
      clr_mem = 1'b1;
      clr_log = 1'b1;
      @(negedge clk);
      clr_mem = 1'b0;
      clr_log = 1'b0;
   endtask

   task automatic put_word(input logic [31:0] a, input logic [31:0] v);
      @(negedge clk);
      ld_en = 1'b1;
      ld_addr = a;
      ld_val = v;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic put_entry(input logic [31:0] off, input logic [31:0] w0, input logic [31:0] w1);
      put_word(BASE + off, w0);
      put_word(BASE + off + 4, w1);
   endtask

   task automatic launch(input logic [23:0] v, input logic [31:0] e, input logic st);
      @(negedge clk);
      vsid = v;
      ea = e;
      is_store = st;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!search_done) @(negedge clk);
   endtask

   task automatic wait_done;
      while (!done) @(negedge clk);
   endtask

   task automatic give_grant(input logic ok);
      @(negedge clk);
      grant_valid = 1'b1;
      grant_ok = ok;
      @(negedge clk);
      grant_valid = 1'b0;
      wait_done();
   endtask

   task automatic t_reset;
      check("R1 busy", {31'b0, busy}, 32'h0);
      check("R1 done", {31'b0, done}, 32'h0);
      check("R1 search_done", {31'b0, search_done}, 32'h0);
      check("R1 found/miss", {30'b0, found, miss}, 32'h0);
      check("R1 withhold", {31'b0, withhold_wr}, 32'h0);
      check("R1 mem req", {30'b0, mem_rd_req, mem_wr_req}, 32'h0);
   endtask

   task automatic t_primary_hit;
      logic [23:0] v = 24'h12_3456;
      logic [31:0] e = 32'h5ABC_D123;
      logic [31:0] g = grp(v, e, 1'b0);
      clear_env();
      put_entry(g + 8,  mkw0(1'b1, v, 1'b1, e), 32'h1111_1180);
      put_entry(g + 24, mkw0(1'b1, v, 1'b0, e), 32'h1234_5180);
      put_entry(g + 40, mkw0(1'b1, v, 1'b0, e), 32'h9999_9180);
      launch(v, e, 1'b0);
      check("R6 found", {31'b0, found}, 32'h1);
      check("R6 pte_off", pte_off, g + 24);
      check("R6 pte_w0", pte_w0, mkw0(1'b1, v, 1'b0, e));
      check("R6 pte_w1", pte_w1, 32'h1234_5180);
      check("R2 first read addr", rd_log[0], BASE + g);
      check("R3 word1 second", rd_log[1], BASE + g + 4);
      check("R3 ascending", rd_log[2], BASE + g + 8);
      check("R3 last read", rd_log[7], BASE + g + 28);
      check("R6 read count", rd_cnt, 8);
      give_grant(1'b1);
      check("R9 no write when set", wr_cnt, 0);
      check("R11 withhold clear", {31'b0, withhold_wr}, 32'h0);
   endtask

   task automatic t_secondary_hit;
      logic [23:0] v = 24'h0F_0F0F;
      logic [31:0] e = 32'h3001_2000;
      logic [31:0] g1 = grp(v, e, 1'b0);
      logic [31:0] g2 = grp(v, e, 1'b1);
      clear_env();
      put_entry(g1,      mkw0(1'b1, v, 1'b1, e), 32'h0000_0180);
      put_entry(g2,      mkw0(1'b1, v, 1'b0, e), 32'h0000_0180);
      put_entry(g2 + 16, mkw0(1'b1, v, 1'b1, e), 32'hCAFE_0180);
      launch(v, e, 1'b0);
      check("R5 found", {31'b0, found}, 32'h1);
      check("R5 pte_off", pte_off, g2 + 16);
      check("R5 pte_w1", pte_w1, 32'hCAFE_0180);
      check("R5 second group addr", rd_log[16], BASE + g2);
      check("R4 read count", rd_cnt, 22);
      give_grant(1'b0);
   endtask

   task automatic t_miss;
      logic [23:0] v = 24'h00_0001;
      logic [31:0] e = 32'h0040_0000;
      logic [31:0] g1 = grp(v, e, 1'b0);
      clear_env();
      put_entry(g1,     mkw0(1'b0, v, 1'b0, e), 32'h0000_0180);
      put_entry(g1 + 8, mkw0(1'b1, v, 1'b0, 32'h0000_0000), 32'h0000_0180);
      launch(v, e, 1'b1);
      check("R7 miss", {30'b0, found, miss}, 32'h1);
      check("R7 read count", rd_cnt, 32);
      wait_done();
      check("R7 no writes", wr_cnt, 0);
   endtask

   task automatic t_rc_store;
      logic [23:0] v = 24'h55_AA55;
      logic [31:0] e = 32'h7FFF_F000;
      logic [31:0] g = grp(v, e, 1'b0);
      clear_env();
      put_entry(g + 56, mkw0(1'b1, v, 1'b0, e), 32'hDEAD_B07E);
      launch(v, e, 1'b1);
      check("R6 last entry off", pte_off, g + 56);
      give_grant(1'b1);
      check("R10 write count", wr_cnt, 2);
      check("R9 ref addr", wr_addr_log[0], BASE + g + 62);
      check("R9 ref data", {24'b0, wr_data_log[0]}, 32'h0000_00B1);
      check("R10 chg addr", wr_addr_log[1], BASE + g + 63);
      check("R10 chg data", {24'b0, wr_data_log[1]}, 32'h0000_00FE);
      check("R10 word in memory", mem[(BASE + g + 60) >> 2], 32'hDEAD_B1FE);
      check("R10 withhold clear", {31'b0, withhold_wr}, 32'h0);
   endtask

   task automatic t_rc_load;
      logic [23:0] v = 24'hAB_CDEF;
      logic [31:0] e = 32'h1234_5000;
      logic [31:0] g = grp(v, e, 1'b0);
      clear_env();
      put_entry(g, mkw0(1'b1, v, 1'b0, e), 32'h0000_017E);
      launch(v, e, 1'b0);
      give_grant(1'b1);
      check("R11 no write", wr_cnt, 0);
      check("R11 withhold", {31'b0, withhold_wr}, 32'h1);
      clear_env();
      put_entry(g, mkw0(1'b1, v, 1'b0, e), 32'h0000_3C3C);
      launch(v, e, 1'b0);
      give_grant(1'b1);
      check("R11 ref only", wr_cnt, 1);
      check("R9 ref addr load", wr_addr_log[0], BASE + g + 6);
      check("R9 ref data load", {24'b0, wr_data_log[0]}, 32'h0000_003D);
      check("R11 withhold after ref", {31'b0, withhold_wr}, 32'h1);
   endtask

   task automatic t_deny;
      logic [23:0] v = 24'h33_4455;
      logic [31:0] e = 32'h0ABC_0000;
      logic [31:0] g = grp(v, e, 1'b0);
      clear_env();
      put_entry(g + 16, mkw0(1'b1, v, 1'b0, e), 32'h0000_0000);
      launch(v, e, 1'b1);
      give_grant(1'b0);
      check("R12 no write", wr_cnt, 0);
      check("R12 withhold clear", {31'b0, withhold_wr}, 32'h0);
   endtask

   task automatic t_busy_start;
      logic [23:0] v = 24'h12_3456;
      logic [31:0] e = 32'h5ABC_D123;
      logic [31:0] g = grp(v, e, 1'b0);
      clear_env();
      put_entry(g + 24, mkw0(1'b1, v, 1'b0, e), 32'h1234_5180);
      @(negedge clk);
      vsid = v;
      ea = e;
      is_store = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      vsid = 24'h0F_0F0F;
      ea = 32'h3001_2000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!search_done) @(negedge clk);
      check("R8 found first", {31'b0, found}, 32'h1);
      check("R8 off of first", pte_off, g + 24);
      check("R8 first addr", rd_log[0], BASE + g);
      give_grant(1'b0);
      @(negedge clk);
      check("R8 idle after", {31'b0, busy}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_primary_hit();
      t_secondary_hit();
      t_miss();
      t_rc_store();
      t_rc_load();
      t_deny();
      t_busy_start();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule